// File: doc/BRIEF.md
# Peripheral Status Register with Deferred Errors

This block keeps the status byte of a peripheral controller and raises its interrupt request. Error events arrive on two classes of input. Immediate events show up in the status byte on the next clock. Deferred events wait in a holding latch and reach the status byte only when the processor issues its next start command. The processor issues start and test strobes. Each command is answered one cycle later with a two-bit condition code and a snapshot of the status byte.

A started transfer keeps the block busy for a fixed number of cycles. It then raises an interrupt request. An immediate hard error or a data parity error during the transfer cuts it short and also raises the interrupt. A punch-check error does not stop the transfer. Each class of error has its own clearing rule. Parity and punch-check indications clear on their own once the processor has seen them. A control-parity error needs the processor clear input. The other hard and deferred errors need the device clear input. The off-line switch makes the device look busy, and it also clears the hopper/stacker indication.

Status byte layout:
- bit 0: hard error.
- bit 1: deferred error, published.
- bit 2: punch check.
- bit 3: data parity.
- bit 5: interrupt pre-empted by a test.
- bits 4, 6 and 7: always zero.

Condition codes:
- 00: accepted or clean.
- 01: status stored.
- 10: busy.
- 11: not operational.

Top module: `devstat_ctrl`

## Requirements
- R1: Synchronous reset clears every stored indication, the interrupt request and the busy state, and drives resp_o, cc_o and stat_o to zero.
- R2: A pulse on any bit of imm_evt_i sets status bit 0. dpar_evt_i sets bit 3 and pchk_evt_i sets bit 2. These bits appear in the status returned by the next test, whose code is 01.
- R3: A pulse on def_evt_i is held in the latch and does not appear in the status. It is published into bit 1 by the next start that reaches a present, on-line, idle device. If bit 0 or bit 1 of that published status is set, the start returns 01 with that status and no transfer begins.
- R4: A start that reaches a present, on-line, idle device with clean bits 0 and 1 returns 00. busy_o then stays high for XFER_LEN cycles, and irq_o rises on the cycle busy_o falls.
- R5: While busy, a pulse on imm_evt_i or dpar_evt_i ends the transfer at that edge and raises irq_o. A pulse on pchk_evt_i alone leaves the transfer running.
- R6: Tests are answered as follows. A busy or off-line device returns 10. A test that finds an interrupt request pending clears the request, returns 01 with bit 5 set, and bit 5 then stays set. Otherwise the test returns 01 when the status byte is nonzero and 00 when it is zero.
- R7: A test that returns 01, or irq_ack_i, clears bits 2, 3 and 5; irq_ack_i also drops irq_o. A set in the same cycle wins over the clear.
- R8: A control-parity event (imm_evt_i bit 0) is cleared only by cpu_clr_i. The other hard events, the deferred latch, published bit 1, and bits 2 and 3 are cleared by dev_clr_i. Bit 0 reads set while either hard source remains.
- R9: While offline_i is high, starts and tests return 10 and change no state. A transfer already running completes. The hopper/stacker source (def_evt_i bit 0) is cleared from both the latch and bit 1.
- R10: A start or test with present_i low returns 11 and changes no state. This check has priority over busy and off-line.
- R11: An immediate and a deferred event in the same cycle are both recorded: bit 0 sets at once and the deferred event is kept for the next start.
- R12: When start_i and test_i are high together, only the start is executed.
- R13: resp_o pulses one cycle after each command. cc_o and stat_o hold until the next command. Events in the command's own cycle are not part of its report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present_i | input | 1 | Addressed device exists on the path |
| offline_i | input | 1 | Off-line switch level |
| start_i | input | 1 | Start-command strobe |
| test_i | input | 1 | Test-status strobe |
| irq_ack_i | input | 1 | Processor accepts the interrupt |
| cpu_clr_i | input | 1 | Processor clear |
| dev_clr_i | input | 1 | Device clear |
| imm_evt_i | input | IMM_W | Immediate hard events; bit 0 is control parity |
| dpar_evt_i | input | 1 | Data parity event |
| pchk_evt_i | input | 1 | Punch-check event |
| def_evt_i | input | DEF_W | Deferred events; bit 0 is hopper/stacker |
| resp_o | output | 1 | Command response valid pulse |
| cc_o | output | 2 | Condition code of last command |
| stat_o | output | 8 | Status byte of last command |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Transfer in progress |

## Verification
The directed cases separate the error classes from one another:
- Immediate, deferred and combined events show whether an event is seen at once or only after a start.
- Control parity against the other hard sources shows which clear input owns which bit.
- Parity and punch-check events during a transfer separate terminating errors from non-terminating ones.

Off-line, absent-device and simultaneous-strobe patterns cover the priority between codes 11, 10 and the normal path. A long mixed pseudo-random run then overlaps clears, sets, acknowledges and commands in the same cycles, which exercises the set-wins rules.

// File: rtl/devstat_pkg.sv
`timescale 1ns/1ps
package devstat_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_HARD  = 0;
  localparam int unsigned BIT_DEFER = 1;
  localparam int unsigned BIT_PCHK  = 2;
  localparam int unsigned BIT_DPAR  = 3;
  localparam int unsigned BIT_IPEND = 5;

  typedef enum logic [1:0] {
    CC_OK     = 2'b00,
    CC_STORED = 2'b01,
    CC_BUSY   = 2'b10,
    CC_NOOP   = 2'b11
  } cc_e;

  function automatic logic [STAT_W-1:0] pack_status(input logic hard, input logic defer,
                                                    input logic pchk, input logic dpar,
                                                    input logic ipend);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_HARD]  = hard;
    s[BIT_DEFER] = defer;
    s[BIT_PCHK]  = pchk;
    s[BIT_DPAR]  = dpar;
    s[BIT_IPEND] = ipend;
    return s;
  endfunction
endpackage

// File: rtl/devstat_sticky.sv
`timescale 1ns/1ps
// Bank of set/clear flags; a set in the same cycle wins over a clear.
module devstat_sticky #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst) q_q <= '0;
    else     q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/devstat_defer.sv
`timescale 1ns/1ps
// Intermediate latch for deferred errors plus the published copy.
module devstat_defer #(
  parameter int unsigned DEF_W    = 2,
  parameter int unsigned HESF_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEF_W-1:0] evt_i,
  input  logic             publish_i,
  input  logic             dev_clr_i,
  input  logic             offline_i,
  output logic [DEF_W-1:0] held_o,
  output logic [DEF_W-1:0] pub_o
);
  for (genvar i = 0; i < DEF_W; i++) begin : g_src
    logic held_q, pub_q, wipe;
    assign wipe = dev_clr_i || (offline_i && (i == HESF_IDX));

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= 1'b0;
        pub_q  <= 1'b0;
      end else begin
        held_q <= ((publish_i ? 1'b0 : held_q) & ~wipe) | evt_i[i];
        pub_q  <= (pub_q & ~wipe) | (publish_i & held_q);
      end
    end

    assign held_o[i] = held_q;
    assign pub_o[i]  = pub_q;
  end
endmodule

// File: rtl/devstat_xfer.sv
`timescale 1ns/1ps
// Transfer timer: busy for XFER_LEN cycles unless aborted.
module devstat_xfer #(
  parameter int unsigned XFER_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic abort_i,
  output logic busy_o,
  output logic end_o
);
  localparam int unsigned CNT_W = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign end_o  = busy_q && (abort_i || (cnt_q == '0));
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(XFER_LEN - 1);
    end else if (end_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/devstat_ctrl.sv
`timescale 1ns/1ps
module devstat_ctrl
  import devstat_pkg::*;
#(
  parameter int unsigned IMM_W    = 3,
  parameter int unsigned DEF_W    = 2,
  parameter int unsigned XFER_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             present_i,
  input  logic             offline_i,
  input  logic             start_i,
  input  logic             test_i,
  input  logic             irq_ack_i,
  input  logic             cpu_clr_i,
  input  logic             dev_clr_i,
  input  logic [IMM_W-1:0] imm_evt_i,
  input  logic             dpar_evt_i,
  input  logic             pchk_evt_i,
  input  logic [DEF_W-1:0] def_evt_i,
  output logic             resp_o,
  output logic [1:0]       cc_o,
  output logic [7:0]       stat_o,
  output logic             irq_o,
  output logic             busy_o
);
  localparam int unsigned NFLAG  = 5;
  localparam int unsigned F_CTL  = 0;
  localparam int unsigned F_OTH  = 1;
  localparam int unsigned F_PCHK = 2;
  localparam int unsigned F_DPAR = 3;
  localparam int unsigned F_IP   = 4;

  logic [NFLAG-1:0]  flag_set, flag_clr, flag_q;
  logic [DEF_W-1:0]  held, pub;
  logic              busy, xfer_end, abort;
  logic              hard, cmd, blocked;
  logic              start_pub, start_go, test_live, test_irq, test_store;
  logic [STAT_W-1:0] base_stat, pub_view;
  logic              irq_q, resp_q;
  cc_e               cc_d, cc_q;
  logic [STAT_W-1:0] stat_d, stat_q;

  // command decode
  assign cmd        = start_i || test_i;
  assign blocked    = offline_i || busy;
  assign hard       = flag_q[F_CTL] || flag_q[F_OTH];
  assign base_stat  = pack_status(hard, |pub, flag_q[F_PCHK], flag_q[F_DPAR], flag_q[F_IP]);
  assign pub_view   = pack_status(hard, (|pub) || (|held), flag_q[F_PCHK], flag_q[F_DPAR],
                                  flag_q[F_IP]);
  assign start_pub  = start_i && present_i && !blocked;
  assign start_go   = start_pub && !pub_view[BIT_HARD] && !pub_view[BIT_DEFER];
  assign test_live  = test_i && !start_i && present_i && !blocked;
  assign test_irq   = test_live && irq_q;
  assign test_store = test_live && (irq_q || (base_stat != '0));
  assign abort      = (|imm_evt_i) || dpar_evt_i;

  // flag set / clear matrix
  always_comb begin
    flag_set         = '0;
    flag_set[F_CTL]  = imm_evt_i[0];
    flag_set[F_OTH]  = |imm_evt_i[IMM_W-1:1];
    flag_set[F_PCHK] = pchk_evt_i;
    flag_set[F_DPAR] = dpar_evt_i;
    flag_set[F_IP]   = test_irq;
    flag_clr         = '0;
    flag_clr[F_CTL]  = cpu_clr_i;
    flag_clr[F_OTH]  = dev_clr_i;
    flag_clr[F_PCHK] = dev_clr_i || irq_ack_i || test_store;
    flag_clr[F_DPAR] = dev_clr_i || irq_ack_i || test_store;
    flag_clr[F_IP]   = irq_ack_i || test_store;
  end

  devstat_sticky #(.W(NFLAG)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  devstat_defer #(.DEF_W(DEF_W), .HESF_IDX(0)) u_defer (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (def_evt_i),
    .publish_i (start_pub),
    .dev_clr_i (dev_clr_i),
    .offline_i (offline_i),
    .held_o    (held),
    .pub_o     (pub)
  );

  devstat_xfer #(.XFER_LEN(XFER_LEN)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .go_i    (start_go),
    .abort_i (abort),
    .busy_o  (busy),
    .end_o   (xfer_end)
  );

  // response selection
  always_comb begin
    cc_d   = cc_q;
    stat_d = stat_q;
    if (cmd) begin
      if (!present_i) begin
        cc_d   = CC_NOOP;
        stat_d = base_stat;
      end else if (blocked) begin
        cc_d   = CC_BUSY;
        stat_d = base_stat;
      end else if (start_i) begin
        cc_d   = start_go ? CC_OK : CC_STORED;
        stat_d = pub_view;
      end else begin
        cc_d   = test_store ? CC_STORED : CC_OK;
        stat_d = base_stat;
        stat_d[BIT_IPEND] = base_stat[BIT_IPEND] || irq_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= 1'b0;
      cc_q   <= CC_OK;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      resp_q <= cmd;
      cc_q   <= cc_d;
      stat_q <= stat_d;
      if (xfer_end)                   irq_q <= 1'b1;
      else if (irq_ack_i || test_irq) irq_q <= 1'b0;
    end
  end

  assign resp_o = resp_q;
  assign cc_o   = cc_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;
  assign busy_o = busy;
endmodule

// File: rtl/devstat_ctrl_chk.sv
`timescale 1ns/1ps
module devstat_ctrl_chk #(
  parameter int unsigned IMM_W    = 3,
  parameter int unsigned DEF_W    = 2,
  parameter int unsigned XFER_LEN = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             present_i,
  input logic             offline_i,
  input logic             start_i,
  input logic             test_i,
  input logic             irq_ack_i,
  input logic             cpu_clr_i,
  input logic             dev_clr_i,
  input logic [IMM_W-1:0] imm_evt_i,
  input logic             dpar_evt_i,
  input logic             pchk_evt_i,
  input logic [DEF_W-1:0] def_evt_i,
  input logic             resp_o,
  input logic [1:0]       cc_o,
  input logic [7:0]       stat_o,
  input logic             irq_o,
  input logic             busy_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_o && !irq_o && !busy_o && cc_o == 2'b00 && stat_o == 8'h00));

  a_r4_irq_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> irq_o);

  a_r10_absent_code: assert property (@(posedge clk) disable iff (rst)
    ((start_i || test_i) && !present_i) |=> (resp_o && cc_o == 2'b11));

  a_r9_offline_code: assert property (@(posedge clk) disable iff (rst)
    ((start_i || test_i) && present_i && offline_i) |=> (cc_o == 2'b10));

  a_r9_offline_no_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && offline_i && !busy_o) |=> !busy_o);

  a_r6_busy_test: assert property (@(posedge clk) disable iff (rst)
    (test_i && !start_i && present_i && busy_o) |=> (cc_o == 2'b10));

  a_r13_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    (start_i || test_i) |=> resp_o);

  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !(start_i || test_i) |=> (!resp_o && $stable(cc_o) && $stable(stat_o)));
endmodule

bind devstat_ctrl devstat_ctrl_chk #(.IMM_W(IMM_W), .DEF_W(DEF_W), .XFER_LEN(XFER_LEN)) u_chk (.*);

// File: tb/devstat_ctrl_tb_top.sv
`timescale 1ns/1ps
module devstat_ctrl_tb_top;
  localparam int unsigned IMM_W = 3;
  localparam int unsigned DEF_W = 2;
  localparam int unsigned XLEN  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic present_i = 1'b1, offline_i = 1'b0, start_i = 1'b0, test_i = 1'b0;
  logic irq_ack_i = 1'b0, cpu_clr_i = 1'b0, dev_clr_i = 1'b0;
  logic [IMM_W-1:0] imm_evt_i = '0;
  logic dpar_evt_i = 1'b0, pchk_evt_i = 1'b0;
  logic [DEF_W-1:0] def_evt_i = '0;
  logic resp_o, irq_o, busy_o;
  logic [1:0] cc_o;
  logic [7:0] stat_o;

  always #4 clk = ~clk;  // 125 MHz

  devstat_ctrl #(.IMM_W(IMM_W), .DEF_W(DEF_W), .XFER_LEN(XLEN)) dut_i (.*);

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_ctl, m_oth, m_pchk, m_dpar, m_ip, m_irq, m_busy, m_resp;
  bit [DEF_W-1:0] m_lat, m_pub;
  int m_cnt;
  bit [1:0] m_cc;
  bit [7:0] m_stat;

  task automatic model_edge();
    bit [7:0] cur, view;
    bit hard_now, take, go, tirq, tstore, ended;
    bit [DEF_W-1:0] wipe, nlat, npub;
    if (rst) begin
      {m_ctl, m_oth, m_pchk, m_dpar, m_ip, m_irq, m_busy, m_resp} = '0;
      m_lat = '0; m_pub = '0; m_cnt = 0; m_cc = 2'b00; m_stat = 8'h00;
      return;
    end
    hard_now = m_ctl | m_oth;
    cur = 8'h00;
    cur[0] = hard_now; cur[1] = (m_pub != 0); cur[2] = m_pchk; cur[3] = m_dpar; cur[5] = m_ip;
    view = cur; view[1] = (m_pub != 0) || (m_lat != 0);
    take = 0; go = 0; tirq = 0; tstore = 0;
    m_resp = start_i || test_i;
    if (start_i || test_i) begin
      if (!present_i)                 begin m_cc = 2'b11; m_stat = cur; end
      else if (offline_i || m_busy)   begin m_cc = 2'b10; m_stat = cur; end
      else if (start_i) begin
        take = 1; go = !(view[0] || view[1]);
        m_cc = go ? 2'b00 : 2'b01; m_stat = view;
      end else begin
        m_stat = cur;
        if (m_irq) begin m_stat[5] = 1; tirq = 1; end
        tstore = m_irq || (cur != 0);
        m_cc = tstore ? 2'b01 : 2'b00;
      end
    end
    ended = m_busy && (m_cnt == 0 || imm_evt_i != 0 || dpar_evt_i);
    if (go)          begin m_busy = 1; m_cnt = XLEN - 1; end
    else if (ended)  m_busy = 0;
    else if (m_busy) m_cnt--;
    if (ended) m_irq = 1;
    else if (irq_ack_i || tirq) m_irq = 0;
    if (cpu_clr_i) m_ctl = 0;
    if (imm_evt_i[0]) m_ctl = 1;
    if (dev_clr_i) m_oth = 0;
    if (imm_evt_i[IMM_W-1:1] != 0) m_oth = 1;
    if (dev_clr_i || irq_ack_i || tstore) begin m_pchk = 0; m_dpar = 0; end
    if (pchk_evt_i) m_pchk = 1;
    if (dpar_evt_i) m_dpar = 1;
    if (irq_ack_i || tstore) m_ip = 0;
    if (tirq) m_ip = 1;
    wipe = dev_clr_i ? '1 : '0;
    if (offline_i) wipe[0] = 1;
    nlat = ((take ? '0 : m_lat) & ~wipe) | def_evt_i;
    npub = (m_pub & ~wipe) | (take ? m_lat : '0);
    m_lat = nlat; m_pub = npub;
  endtask

  task automatic compare();
    vectors++;
    if (resp_o !== m_resp || cc_o !== m_cc || stat_o !== m_stat ||
        irq_o !== m_irq || busy_o !== m_busy) begin
      fails++;
      $display("FAIL %s t=%0t: got resp=%b cc=%b stat=%h irq=%b busy=%b exp resp=%b cc=%b stat=%h irq=%b busy=%b",
               cur_req, $time, resp_o, cc_o, stat_o, irq_o, busy_o,
               m_resp, m_cc, m_stat, m_irq, m_busy);
    end
  endtask

  always @(posedge clk) begin
    model_edge();
    #2;
    if (!done) compare();
  end

  task automatic chk(input string req, input int got, input int exp, input string what);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
    end
  endtask

  task automatic cmd_start(); @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic cmd_test();  @(negedge clk); test_i  = 1; @(negedge clk); test_i  = 0; endtask
  task automatic do_ack();    @(negedge clk); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0; endtask
  task automatic do_dclr();   @(negedge clk); dev_clr_i = 1; @(negedge clk); dev_clr_i = 0; endtask
  task automatic do_cclr();   @(negedge clk); cpu_clr_i = 1; @(negedge clk); cpu_clr_i = 0; endtask
  task automatic ev(input logic [IMM_W-1:0] im, input logic dp, input logic pc,
                    input logic [DEF_W-1:0] df);
    @(negedge clk);
    imm_evt_i = im; dpar_evt_i = dp; pchk_evt_i = pc; def_evt_i = df;
    @(negedge clk);
    imm_evt_i = '0; dpar_evt_i = 0; pchk_evt_i = 0; def_evt_i = '0;
  endtask
  task automatic wait_idle(); while (busy_o) @(negedge clk); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", {resp_o, irq_o, busy_o}, 0, "flags after reset");
    chk("R1", {cc_o, stat_o}, 0, "code/status after reset");

    cur_req = "R4";
    cmd_start();
    chk("R4", cc_o, 0, "start code");
    chk("R4", busy_o, 1, "busy after start");
    wait_idle();
    chk("R4", irq_o, 1, "irq at end");
    do_ack();
    chk("R7", irq_o, 0, "irq after ack");

    cur_req = "R6";
    cmd_start(); wait_idle();
    cmd_test();
    chk("R6", {cc_o, stat_o}, {2'b01, 8'h20}, "test pre-empting irq");
    chk("R6", irq_o, 0, "irq cleared by test");
    cmd_test();
    chk("R6", {cc_o, stat_o}, {2'b01, 8'h20}, "bit5 held");
    cmd_test();
    chk("R7", {cc_o, stat_o}, {2'b00, 8'h00}, "bit5 cleared by 01 test");

    cur_req = "R2";
    ev(3'b010, 0, 0, 2'b00);
    cmd_test();
    chk("R2", {cc_o, stat_o}, {2'b01, 8'h01}, "hard event");
    cmd_test();
    chk("R8", {cc_o, stat_o}, {2'b01, 8'h01}, "hard event needs manual clear");
    do_dclr(); cmd_test();
    chk("R8", {cc_o, stat_o}, {2'b00, 8'h00}, "device clear");

    cur_req = "R8";
    ev(3'b001, 0, 0, 2'b00);
    do_dclr(); cmd_test();
    chk("R8", {cc_o, stat_o}, {2'b01, 8'h01}, "control parity survives device clear");
    do_cclr(); cmd_test();
    chk("R8", {cc_o, stat_o}, {2'b00, 8'h00}, "processor clear");

    cur_req = "R7";
    ev(3'b000, 1, 1, 2'b00);
    cmd_test();
    chk("R2", {cc_o, stat_o}, {2'b01, 8'h0C}, "parity and punch check");
    cmd_test();
    chk("R7", {cc_o, stat_o}, {2'b00, 8'h00}, "auto-cleared by test");
    ev(3'b000, 1, 0, 2'b00);
    do_ack(); cmd_test();
    chk("R7", {cc_o, stat_o}, {2'b00, 8'h00}, "auto-cleared by ack");

    cur_req = "R3";
    ev(3'b000, 0, 0, 2'b10);
    cmd_test();
    chk("R3", {cc_o, stat_o}, {2'b00, 8'h00}, "deferred event hidden");
    cmd_start();
    chk("R3", {cc_o, stat_o}, {2'b01, 8'h02}, "published at start");
    chk("R3", busy_o, 0, "rejected start not busy");
    cmd_test();
    chk("R3", {cc_o, stat_o}, {2'b01, 8'h02}, "published bit held");
    do_dclr(); cmd_test();
    chk("R8", {cc_o, stat_o}, {2'b00, 8'h00}, "deferred cleared");

    cur_req = "R11";
    ev(3'b010, 0, 0, 2'b10);
    cmd_test();
    chk("R11", {cc_o, stat_o}, {2'b01, 8'h01}, "immediate part");
    cmd_start();
    chk("R11", {cc_o, stat_o}, {2'b01, 8'h03}, "deferred part kept");
    do_dclr(); cmd_test();
    chk("R11", {cc_o, stat_o}, {2'b00, 8'h00}, "cleared");

    cur_req = "R5";
    cmd_start(); repeat (2) @(negedge clk);
    ev(3'b000, 1, 0, 2'b00);
    chk("R5", {busy_o, irq_o}, {1'b0, 1'b1}, "parity terminates");
    do_ack();
    cmd_start(); @(negedge clk);
    ev(3'b000, 0, 1, 2'b00);
    chk("R5", busy_o, 1, "punch check keeps running");
    wait_idle(); do_ack(); cmd_test();
    chk("R5", {cc_o, stat_o}, {2'b00, 8'h00}, "after punch check ack");

    cur_req = "R9";
    @(negedge clk); offline_i = 1;
    cmd_start();
    chk("R9", {cc_o, busy_o}, {2'b10, 1'b0}, "offline start");
    cmd_test();
    chk("R9", cc_o, 2'b10, "offline test");
    ev(3'b000, 0, 0, 2'b01);
    @(negedge clk); offline_i = 0;
    cmd_start();
    chk("R9", cc_o, 2'b00, "hopper indication wiped by offline");
    wait_idle(); do_ack();
    cmd_start(); @(negedge clk); offline_i = 1;
    wait_idle();
    chk("R9", irq_o, 1, "running order completes offline");
    @(negedge clk); offline_i = 0;
    do_ack();

    cur_req = "R10";
    @(negedge clk); present_i = 0;
    cmd_test();
    chk("R10", cc_o, 2'b11, "absent test");
    cmd_start();
    chk("R10", {cc_o, busy_o}, {2'b11, 1'b0}, "absent start");
    @(negedge clk); present_i = 1;

    cur_req = "R12";
    @(negedge clk); start_i = 1; test_i = 1;
    @(negedge clk); start_i = 0; test_i = 0;
    chk("R12", {cc_o, busy_o}, {2'b00, 1'b1}, "start wins over test");
    wait_idle(); do_ack();

    cur_req = "R13";
    for (int k = 0; k < 900; k++) begin
      @(negedge clk);
      start_i    = ($urandom % 12) == 0;
      test_i     = ($urandom % 10) == 0;
      irq_ack_i  = ($urandom % 15) == 0;
      cpu_clr_i  = ($urandom % 40) == 0;
      dev_clr_i  = ($urandom % 30) == 0;
      imm_evt_i  = (($urandom % 25) == 0) ? IMM_W'($urandom) : '0;
      dpar_evt_i = ($urandom % 30) == 0;
      pchk_evt_i = ($urandom % 30) == 0;
      def_evt_i  = (($urandom % 20) == 0) ? DEF_W'($urandom) : '0;
      present_i  = ($urandom % 20) != 0;
      if (($urandom % 50) == 0) offline_i = ~offline_i;
    end
    @(negedge clk);
    {start_i, test_i, irq_ack_i, cpu_clr_i, dev_clr_i, dpar_evt_i, pchk_evt_i, offline_i} = '0;
    imm_evt_i = '0; def_evt_i = '0; present_i = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule